// File: doc/BRIEF.md
# Synchronous Half-Duplex Byte Shift Port

This block moves 8-bit bytes over a single bidirectional data pin while driving a shift clock of its own on a separate output pin. The shift clock runs at one twelfth of the system clock by default (parameter `CLK_DIV`). Only one direction is active at a time. When the port is idle, the clock pin rests high and the data pin is released.

A byte write while the port is idle starts a transmission. The byte leaves least significant bit first, with one clock pulse per bit, and the transmit-done flag rises once the eighth bit has completed. No write starts a reception. Instead, the port begins receiving as soon as it is idle, reception is enabled and the receive-done flag is clear. It then issues eight clock pulses and captures one bit on each rising clock edge. The assembled byte is presented on the read port, and the receive-done flag is raised. Both flags stay set until the matching clear input is pulsed.

Top module: `sshift_port`

## Requirements
- R1: After reset, `sclk_o` is 1, `dat_oe` is 0, `ti` and `ri` are 0 and `rd_data` is 0x00.
- R2: A write (`wr_en`=1) sampled while idle starts a transmission: from the next cycle `dat_oe` is 1 for exactly 8×`CLK_DIV` cycles, and bit j of the written byte (j=0 first) is on `dat_o` for `CLK_DIV` cycles; afterwards `dat_oe` returns to 0.
- R3: While active, each bit period of `CLK_DIV` cycles shows `sclk_o`=0 for the first `CLK_DIV`/2 cycles and 1 for the rest, giving exactly 8 rising edges per byte; when idle, `sclk_o` is 1.
- R4: `dat_o` changes only at the cycle where `sclk_o` falls, and it is stable while `sclk_o` is high.
- R5: `ti` becomes 1 exactly 8×`CLK_DIV` cycles after the edge that accepted the write, and it stays 1 until `ti_clr` is sampled high.
- R6: A reception starts only when the port is idle, `rx_en`=1 and `ri`=0. With `rx_en`=0, or with `ri`=1, `sclk_o` stays high.
- R7: During reception `dat_oe` stays 0. `dat_i` is sampled just before each rising `sclk_o`, and the first bit becomes bit 0. Exactly 8×`CLK_DIV` cycles after the start edge, `rd_data` holds the byte and `ri` is 1.
- R8: A write while a transmission or reception is in progress is ignored. The bits of the current transmission are unchanged, and no transmission follows a reception because of it.
- R9: When a write and the reception start condition occur in the same idle cycle, the write wins and a transmission starts.
- R10: `ri_clr` clears `ri` and `ti_clr` clears `ti`, one cycle after they are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe, starts a transmission when idle |
| wr_data | input | 8 | Byte to transmit |
| rd_data | output | 8 | Last received byte |
| rx_en | input | 1 | Reception enable |
| ti_clr | input | 1 | Clears the transmit-done flag |
| ri_clr | input | 1 | Clears the receive-done flag |
| ti | output | 1 | Transmit-done flag |
| ri | output | 1 | Receive-done flag |
| sclk_o | output | 1 | Generated shift clock, idles high |
| dat_o | output | 1 | Data pin output value |
| dat_oe | output | 1 | Data pin output enable |
| dat_i | input | 1 | Data pin input value |

## Verification
Every result is due a fixed number of cycles after the edge that accepts the write or the reception start. The bench counts cycles from that edge and, at the falling clock edge after edge k+t, predicts `sclk_o`, `dat_oe` and `dat_o` from t mod `CLK_DIV` and t / `CLK_DIV`. The flags and the received byte are checked at exactly t = 8×`CLK_DIV`, one cycle after the last bit period. Receive data is driven in the low half of each bit period, so it is settled at the sampling edge. Flag clears are checked one cycle after the pulse.

// File: rtl/sshift_pkg.sv
package sshift_pkg;

  typedef enum logic [1:0] {
    PS_IDLE = 2'd0,
    PS_TX   = 2'd1,
    PS_RX   = 2'd2
  } port_state_t;

  // cycles in the low half of one shift clock period
  function automatic int unsigned low_cycles(input int unsigned div);
    return div / 2;
  endfunction

  // cycles from the start edge to the flag edge
  function automatic int unsigned frame_cycles(input int unsigned div,
                                               input int unsigned bits);
    return div * bits;
  endfunction

endpackage

// File: rtl/sshift_timer.sv
module sshift_timer #(
  parameter int unsigned CLK_DIV = 12,
  parameter int unsigned WORD_W  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  output logic clk_low,
  output logic rise_pt,
  output logic bit_end,
  output logic frame_end
);
  import sshift_pkg::*;

  localparam int unsigned PH_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int unsigned BC_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam int unsigned HALF  = low_cycles(CLK_DIV);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CLK_DIV - 1);
  localparam logic [PH_W-1:0] PH_RISE = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);
  localparam logic [BC_W-1:0] BC_LAST = BC_W'(WORD_W - 1);

  logic [PH_W-1:0] phase_q;
  logic [BC_W-1:0] bitn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      bitn_q  <= '0;
    end else if (!busy) begin
      phase_q <= '0;
      bitn_q  <= '0;
    end else if (phase_q == PH_LAST) begin
      phase_q <= '0;
      bitn_q  <= (bitn_q == BC_LAST) ? '0 : bitn_q + 1'b1;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign clk_low   = busy && (phase_q < PH_HALF);
  assign rise_pt   = busy && (phase_q == PH_RISE);
  assign bit_end   = busy && (phase_q == PH_LAST);
  assign frame_end = bit_end && (bitn_q == BC_LAST);

  AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(bitn_q) < int'(WORD_W))) else $error("bit index out of range"); // R3
  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(phase_q) < int'(CLK_DIV))) else $error("phase out of range"); // R3

endmodule

// File: rtl/sshift_datapath.sv
module sshift_datapath #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_tx,
  input  logic [WORD_W-1:0] load_val,
  input  logic              tx_shift,
  input  logic              rx_capture,
  input  logic              rx_commit,
  input  logic              din,
  output logic              dout_bit,
  output logic [WORD_W-1:0] rx_word
);

  logic [WORD_W-1:0] sreg_q;
  logic [WORD_W-1:0] rbuf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
    end else if (load_tx) begin
      sreg_q <= load_val;
    end else if (tx_shift) begin
      sreg_q <= {1'b0, sreg_q[WORD_W-1:1]};
    end else if (rx_capture) begin
      sreg_q <= {din, sreg_q[WORD_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rbuf_q <= '0;
    else if (rx_commit) rbuf_q <= sreg_q;
  end

  assign dout_bit = sreg_q[0];
  assign rx_word  = rbuf_q;

  AST_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_tx && (tx_shift || rx_capture))) else $error("load during shift"); // R8

endmodule

// File: rtl/sshift_ctrl.sv
module sshift_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic rx_en,
  input  logic ti_clr,
  input  logic ri_clr,
  input  logic frame_end,
  output logic start_tx,
  output logic is_tx,
  output logic is_rx,
  output logic busy,
  output logic ti,
  output logic ri
);
  import sshift_pkg::*;

  port_state_t st_q, st_d;
  logic ti_q, ri_q;
  logic start_rx;

  assign start_tx = (st_q == PS_IDLE) && wr_en;
  assign start_rx = (st_q == PS_IDLE) && !wr_en && rx_en && !ri_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_IDLE: begin
        if (start_tx)      st_d = PS_TX;
        else if (start_rx) st_d = PS_RX;
      end
      PS_TX, PS_RX: if (frame_end) st_d = PS_IDLE;
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PS_IDLE;
      ti_q <= 1'b0;
      ri_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == PS_TX && frame_end) ti_q <= 1'b1;
      else if (ti_clr)                ti_q <= 1'b0;
      if (st_q == PS_RX && frame_end) ri_q <= 1'b1;
      else if (ri_clr)                ri_q <= 1'b0;
    end
  end

  assign is_tx = (st_q == PS_TX);
  assign is_rx = (st_q == PS_RX);
  assign busy  = is_tx || is_rx;
  assign ti    = ti_q;
  assign ri    = ri_q;

  AST_TI_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (is_tx && frame_end) |=> ti) else $error("ti not set"); // R5
  AST_RI_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rx && frame_end) |=> ri) else $error("ri not set"); // R7
  AST_RX_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(is_rx) |-> $past(rx_en && !ri && !busy)) else $error("rx start gate"); // R6
  AST_WR_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && wr_en) |=> is_tx) else $error("write lost"); // R9
  AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rx && wr_en && !frame_end) |=> is_rx) else $error("write broke rx"); // R8

endmodule

// File: rtl/sshift_port.sv
module sshift_port #(
  parameter int unsigned CLK_DIV = 12,
  parameter int unsigned WORD_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  input  logic              rx_en,
  input  logic              ti_clr,
  input  logic              ri_clr,
  output logic              ti,
  output logic              ri,
  output logic              sclk_o,
  output logic              dat_o,
  output logic              dat_oe,
  input  logic              dat_i
);

  logic start_tx, is_tx, is_rx, busy;
  logic clk_low, rise_pt, bit_end, frame_end;
  logic dout_bit;

  sshift_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rx_en     (rx_en),
    .ti_clr    (ti_clr),
    .ri_clr    (ri_clr),
    .frame_end (frame_end),
    .start_tx  (start_tx),
    .is_tx     (is_tx),
    .is_rx     (is_rx),
    .busy      (busy),
    .ti        (ti),
    .ri        (ri)
  );

  sshift_timer #(.CLK_DIV(CLK_DIV), .WORD_W(WORD_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .clk_low   (clk_low),
    .rise_pt   (rise_pt),
    .bit_end   (bit_end),
    .frame_end (frame_end)
  );

  sshift_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_tx    (start_tx),
    .load_val   (wr_data),
    .tx_shift   (is_tx && bit_end),
    .rx_capture (is_rx && rise_pt),
    .rx_commit  (is_rx && frame_end),
    .din        (dat_i),
    .dout_bit   (dout_bit),
    .rx_word    (rd_data)
  );

  assign sclk_o = !clk_low;
  assign dat_oe = is_tx;
  assign dat_o  = is_tx ? dout_bit : 1'b1;

  AST_IDLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk_o) else $error("clock not idle high"); // R3
  AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_oe && $past(dat_oe) && !$stable(dat_o)) |-> !sclk_o) else $error("data moved while clock high"); // R4
  AST_NO_DRIVE_RX: assert property (@(posedge clk) disable iff (!rst_n)
    is_rx |-> !dat_oe) else $error("pin driven in rx"); // R7

endmodule

// File: tb/sim_sshift_port.sv
module sim_sshift_port;
  localparam int DIV   = 12;
  localparam int HALF  = DIV / 2;
  localparam int FRAME = 8 * DIV;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic rx_en = 1'b0, ti_clr = 1'b0, ri_clr = 1'b0;
  logic ti, ri, sclk_o, dat_o, dat_oe;
  logic dat_i = 1'b1;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  sshift_port #(.CLK_DIV(DIV), .WORD_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .rx_en(rx_en), .ti_clr(ti_clr), .ri_clr(ri_clr),
    .ti(ti), .ri(ri), .sclk_o(sclk_o), .dat_o(dat_o), .dat_oe(dat_oe),
    .dat_i(dat_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // transmit one byte; optional write injected during bit 2 (R8)
  task automatic tx_byte(input logic [7:0] b, input bit inj);
    bit bad = 0;
    int act = 0, exp = 0;
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(posedge clk);
    for (int t = 0; t < FRAME; t++) begin
      @(negedge clk);
      if (t == 0) wr_en = 1'b0;
      if (inj && t == 2 * DIV) begin wr_en = 1'b1; wr_data = ~b; end
      if (inj && t == 2 * DIV + 1) wr_en = 1'b0;
      exp = {29'd0, 1'b1, ((t % DIV) >= HALF), b[t / DIV]};
      act = {29'd0, dat_oe, sclk_o, dat_o};
      if (!bad && act != exp) begin
        bad = 1;
        $display("FAIL R2/R3/R4 tx byte 0x%0h cycle %0d actual=0x%0h expected=0x%0h", b, t, act, exp);
      end
    end
    checks++; if (bad) errors++;
    @(negedge clk);
    chk(!dat_oe && sclk_o && ti, "R5 ti after frame", {dat_oe, sclk_o, ti}, 3'b011);
    ti_clr = 1'b1;
    @(negedge clk); ti_clr = 1'b0;
    chk(!ti, "R10 ti_clr", ti, 0);
  endtask

  // receive one byte; optional write injected during bit 1 (R8)
  task automatic rx_byte(input logic [7:0] b, input bit inj);
    bit bad = 0;
    int act = 0, exp = 0;
    @(negedge clk); rx_en = 1'b1;
    @(posedge clk);
    for (int t = 0; t < FRAME; t++) begin
      @(negedge clk);
      dat_i = b[t / DIV];
      if (inj && t == DIV) begin wr_en = 1'b1; wr_data = 8'hA5; end
      if (inj && t == DIV + 1) wr_en = 1'b0;
      exp = {30'd0, 1'b0, ((t % DIV) >= HALF)};
      act = {30'd0, dat_oe, sclk_o};
      if (!bad && act != exp) begin
        bad = 1;
        $display("FAIL R3/R7 rx byte 0x%0h cycle %0d actual=0x%0h expected=0x%0h", b, t, act, exp);
      end
    end
    checks++; if (bad) errors++;
    @(negedge clk);
    chk(ri && rd_data == b, "R7 rx data", {ri, rd_data}, {1'b1, b});
    rx_en = 1'b0;
    if (inj) begin
      repeat (3) @(negedge clk);
      chk(!dat_oe && !ti && sclk_o, "R8 write ignored during rx", {dat_oe, ti, sclk_o}, 3'b001);
    end
    ri_clr = 1'b1;
    @(negedge clk); ri_clr = 1'b0;
    chk(!ri, "R10 ri_clr", ri, 0);
  endtask

  task automatic hold_quiet(input string req);
    bit bad = 0;
    for (int t = 0; t < 3 * DIV; t++) begin
      @(negedge clk);
      if (!sclk_o) bad = 1;
    end
    chk(!bad, req, bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(sclk_o && !dat_oe && !ti && !ri && rd_data == 8'h00, "R1 reset state",
        {sclk_o, dat_oe, ti, ri, rd_data}, 12'h800);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5: every byte value transmitted
    for (int v = 0; v < 256; v++) tx_byte(8'(v), 1'b0);
    // R8: write during transmission ignored
    tx_byte(8'h3C, 1'b1);
    // R7: every byte value received
    for (int v = 0; v < 256; v++) rx_byte(8'(v ^ 8'h5A), 1'b0);
    // R8: write during reception ignored
    rx_byte(8'hC3, 1'b1);

    // R6: rx_en low -> no clock
    hold_quiet("R6 rx_en=0 keeps clock idle");
    // R6: ri set blocks start
    rx_byte(8'h81, 1'b0);
    @(negedge clk); rx_en = 1'b1;
    // rx_byte already cleared ri; set it again by a fresh reception without clear
    @(posedge clk);
    for (int t = 0; t < FRAME; t++) begin @(negedge clk); dat_i = 1'b0; end
    @(negedge clk);
    chk(ri, "R6 ri set before gate test", ri, 1);
    hold_quiet("R6 ri=1 blocks reception");
    rx_en = 1'b0;
    ri_clr = 1'b1; @(negedge clk); ri_clr = 1'b0;

    // R9: write and rx start in the same cycle
    @(negedge clk); rx_en = 1'b1; wr_en = 1'b1; wr_data = 8'h96;
    @(negedge clk); wr_en = 1'b0;
    chk(dat_oe && dat_o == 1'b0, "R9 write wins over rx start", {dat_oe, dat_o}, 2'b10);
    rx_en = 1'b0;
    repeat (FRAME + 4) @(negedge clk);
    chk(ti && !ri && sclk_o, "R9 transmission completed", {ti, ri, sclk_o}, 3'b101);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule